// File: doc/BRIEF.md
# Card Interface Power Sequencer

This block sets the power state of an SD/MMC card interface and decides, for each state, whether the clock, command and data pads are driven and at what level. Software writes a 2-bit power code together with a direction-polarity bit. The block moves between four states: a hardware-reset state with every pad released, a power-cycle state that holds every line low so the card cannot be fed through its signal pins, an off state that holds every line high, and an on state in which the card is clocked.

On entry to the on state, the command and data lines stay parked high while a counter tallies card-clock edges. The card-clock edges arrive as one-cycle pulses from the clock generator. Once the required number of edges has been seen, the interface-enable output rises and the pads follow the command and data paths. The expected order of writes is power-cycle, then off, then on, with at least 1 ms spent in off. The block does not enforce that wait. Two external level-shifter direction pins report which side drives each line. Their sense can be inverted by the polarity bit.

Top module: `card_pwr_seq`

## Requirements
- R1: Power codes on `wr_pwr_i` are 2'b10 = power-cycle, 2'b00 = off and 2'b11 = on. A write (`wr_en_i` high at a clock edge) takes effect on that edge, and `wr_pol_i` is loaded by every write.
- R2: Code 2'b01 is reserved. Writing it leaves the power state unchanged, while the polarity bit is still loaded.
- R3: Asserting `rst_ni` low puts the block at once into the reset state: all pad output-enables low, all pad levels low, polarity 0 and `if_en_o` low. Writing 2'b00 while in the reset state keeps the reset state.
- R4: In power-cycle, the clock, command and all data pads are driven (output-enable 1) at level 0.
- R5: In off, the clock, command and all data pads are driven at level 1.
- R6: In on, before the interface is enabled, `pad_ck_o` follows `card_clk_i` with its enable set, and the command and data pads are driven at level 1.
- R7: In on, each `card_tick_i` pulse advances a count from 0. The pulse that arrives when 74 edges have already been counted raises `if_en_o` on that same clock edge. Pulses outside on are not counted, and neither is a pulse in the cycle of the write that enters on.
- R8: While `if_en_o` is high, the command and data pad levels and enables follow `dp_cmd_i`, `dp_cmd_oe_i`, `dp_dat_i` and `dp_dat_oe_i`.
- R9: Each direction output is its line's enable (the datapath enable when enabled, otherwise 1; 0 in the reset state), XOR the polarity bit.
- R10: A write that leaves on clears the count and `if_en_o` on the same edge, even if a tick arrives in that cycle.
- R11: Writing 2'b11 while already in on neither restarts the count nor drops `if_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control write strobe |
| wr_pwr_i | input | 2 | Power code written |
| wr_pol_i | input | 1 | Direction polarity written |
| card_clk_i | input | 1 | Card clock level, passed to the clock pad in on |
| card_tick_i | input | 1 | One-cycle pulse per card-clock edge |
| dp_cmd_i | input | 1 | Command level from the command path |
| dp_cmd_oe_i | input | 1 | Command drive enable from the command path |
| dp_dat_i | input | DATA_W | Data levels from the data path |
| dp_dat_oe_i | input | 1 | Data drive enable from the data path |
| pad_ck_o | output | 1 | Clock pad level |
| pad_ck_oe_o | output | 1 | Clock pad enable |
| pad_cmd_o | output | 1 | Command pad level |
| pad_cmd_oe_o | output | 1 | Command pad enable |
| pad_dat_o | output | DATA_W | Data pad levels |
| pad_dat_oe_o | output | DATA_W | Data pad enables |
| dir_cmd_o | output | 1 | Command transceiver direction |
| dir_dat_o | output | 1 | Data transceiver direction |
| if_en_o | output | 1 | Interface enabled after warm-up |

## Verification
The warm-up counter and a state write can act on the same clock edge. The bench raises a card-clock tick in the very cycle that software writes off, once the count has reached its final value, and expects `if_en_o` to stay low and the pads to show the off pattern. It then writes on again and expects a full, fresh count of 75 ticks. The reverse case is also driven: a tick that coincides with the write entering on, which must not be counted.

// File: rtl/card_pwr_pkg.sv
package card_pwr_pkg;
  typedef enum logic [1:0] {
    ST_HIZ   = 2'd0,
    ST_CYCLE = 2'd1,
    ST_OFF   = 2'd2,
    ST_ON    = 2'd3
  } pwr_state_e;

  localparam logic [1:0] CODE_OFF   = 2'b00;
  localparam logic [1:0] CODE_CYCLE = 2'b10;
  localparam logic [1:0] CODE_ON    = 2'b11;
endpackage

// File: rtl/card_pwr_fsm.sv
module card_pwr_fsm
  import card_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_pwr_i,
  input  logic       wr_pol_i,
  output pwr_state_e state_q_o,
  output pwr_state_e state_d_o,
  output logic       pol_q_o
);
  pwr_state_e state_q, state_d;
  logic       pol_q;

  always_comb begin
    state_d = state_q;
    if (wr_en_i) begin
      unique case (wr_pwr_i)
        CODE_OFF:   state_d = (state_q == ST_HIZ) ? ST_HIZ : ST_OFF;
        CODE_CYCLE: state_d = ST_CYCLE;
        CODE_ON:    state_d = ST_ON;
        default:    state_d = state_q; // reserved code
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HIZ;
      pol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_en_i) pol_q <= wr_pol_i;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign pol_q_o   = pol_q;
endmodule

// File: rtl/card_pwr_warmup.sv
module card_pwr_warmup #(
  parameter int unsigned WARMUP_CLKS = 74,
  localparam int unsigned CNT_W = $clog2(WARMUP_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARMUP_CLKS);

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (tick_i && !ready_q) begin
      if (cnt_q == LAST) ready_q <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/card_pwr_pads.sv
module card_pwr_pads
  import card_pwr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  pwr_state_e        state_i,
  input  logic              ready_i,
  input  logic              pol_i,
  input  logic              card_clk_i,
  input  logic              dp_cmd_i,
  input  logic              dp_cmd_oe_i,
  input  logic [DATA_W-1:0] dp_dat_i,
  input  logic              dp_dat_oe_i,
  output logic              pad_ck_o,
  output logic              pad_ck_oe_o,
  output logic              pad_cmd_o,
  output logic              pad_cmd_oe_o,
  output logic [DATA_W-1:0] pad_dat_o,
  output logic [DATA_W-1:0] pad_dat_oe_o,
  output logic              dir_cmd_o,
  output logic              dir_dat_o
);
  logic force_oe, force_lvl, pass;

  always_comb begin
    force_oe  = (state_i != ST_HIZ);
    force_lvl = (state_i == ST_OFF) || (state_i == ST_ON);
    pass      = (state_i == ST_ON) && ready_i;
  end

  assign pad_ck_oe_o = force_oe;
  assign pad_ck_o    = (state_i == ST_ON) ? card_clk_i : force_lvl;

  assign pad_cmd_oe_o = pass ? dp_cmd_oe_i : force_oe;
  assign pad_cmd_o    = pass ? dp_cmd_i    : force_lvl;

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign pad_dat_oe_o[g] = pass ? dp_dat_oe_i : force_oe;
    assign pad_dat_o[g]    = pass ? dp_dat_i[g] : force_lvl;
  end

  assign dir_cmd_o = (pass ? dp_cmd_oe_i : force_oe) ^ pol_i;
  assign dir_dat_o = (pass ? dp_dat_oe_i : force_oe) ^ pol_i;
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
  import card_pwr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WARMUP_CLKS = 74,
  localparam int unsigned CNT_W      = $clog2(WARMUP_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_pwr_i,
  input  logic              wr_pol_i,
  input  logic              card_clk_i,
  input  logic              card_tick_i,
  input  logic              dp_cmd_i,
  input  logic              dp_cmd_oe_i,
  input  logic [DATA_W-1:0] dp_dat_i,
  input  logic              dp_dat_oe_i,
  output logic              pad_ck_o,
  output logic              pad_ck_oe_o,
  output logic              pad_cmd_o,
  output logic              pad_cmd_oe_o,
  output logic [DATA_W-1:0] pad_dat_o,
  output logic [DATA_W-1:0] pad_dat_oe_o,
  output logic              dir_cmd_o,
  output logic              dir_dat_o,
  output logic              if_en_o
);
  pwr_state_e       state_q, state_d;
  logic             pol_q;
  logic             run;
  logic [CNT_W-1:0] cnt;

  card_pwr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_pwr_i  (wr_pwr_i),
    .wr_pol_i  (wr_pol_i),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .pol_q_o   (pol_q)
  );

  // count only while on both before and after this edge
  assign run = (state_q == ST_ON) && (state_d == ST_ON);

  card_pwr_warmup #(.WARMUP_CLKS(WARMUP_CLKS)) u_warmup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (card_tick_i),
    .cnt_o   (cnt),
    .ready_o (if_en_o)
  );

  card_pwr_pads #(.DATA_W(DATA_W)) u_pads (
    .state_i      (state_q),
    .ready_i      (if_en_o),
    .pol_i        (pol_q),
    .card_clk_i   (card_clk_i),
    .dp_cmd_i     (dp_cmd_i),
    .dp_cmd_oe_i  (dp_cmd_oe_i),
    .dp_dat_i     (dp_dat_i),
    .dp_dat_oe_i  (dp_dat_oe_i),
    .pad_ck_o     (pad_ck_o),
    .pad_ck_oe_o  (pad_ck_oe_o),
    .pad_cmd_o    (pad_cmd_o),
    .pad_cmd_oe_o (pad_cmd_oe_o),
    .pad_dat_o    (pad_dat_o),
    .pad_dat_oe_o (pad_dat_oe_o),
    .dir_cmd_o    (dir_cmd_o),
    .dir_dat_o    (dir_dat_o)
  );
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk
  import card_pwr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WARMUP_CLKS = 74,
  localparam int unsigned CNT_W      = $clog2(WARMUP_CLKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_pwr_i,
  input logic              card_tick_i,
  input logic [1:0]        state_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              if_en_o,
  input logic              pad_ck_o,
  input logic              pad_ck_oe_o,
  input logic              pad_cmd_o,
  input logic              pad_cmd_oe_o,
  input logic [DATA_W-1:0] pad_dat_o,
  input logic [DATA_W-1:0] pad_dat_oe_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARMUP_CLKS);

  AST_RESERVED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_pwr_i == 2'b01) |=> state_q == $past(state_q)); // R2

  AST_RESET_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIZ) |-> (!pad_ck_oe_o && !pad_cmd_oe_o && pad_dat_oe_o == '0)); // R3

  AST_CYCLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CYCLE) |-> (pad_ck_oe_o && pad_cmd_oe_o && &pad_dat_oe_o
                               && !pad_ck_o && !pad_cmd_o && pad_dat_o == '0)); // R4

  AST_OFF_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |-> (pad_ck_oe_o && pad_cmd_oe_o && &pad_dat_oe_o
                             && pad_ck_o && pad_cmd_o && &pad_dat_o)); // R5

  AST_PARKED_BEFORE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !if_en_o) |-> (pad_cmd_o && pad_cmd_oe_o && &pad_dat_o)); // R6

  AST_READY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(if_en_o) |-> ($past(card_tick_i) && $past(cnt) == LAST)); // R7

  AST_LEAVE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ON) |-> (cnt == '0 && !if_en_o)); // R10
endmodule

bind card_pwr_seq card_pwr_seq_chk #(.DATA_W(DATA_W), .WARMUP_CLKS(WARMUP_CLKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_pwr_i     (wr_pwr_i),
  .card_tick_i  (card_tick_i),
  .state_q      (state_q),
  .cnt          (cnt),
  .if_en_o      (if_en_o),
  .pad_ck_o     (pad_ck_o),
  .pad_ck_oe_o  (pad_ck_oe_o),
  .pad_cmd_o    (pad_cmd_o),
  .pad_cmd_oe_o (pad_cmd_oe_o),
  .pad_dat_o    (pad_dat_o),
  .pad_dat_oe_o (pad_dat_oe_o)
);

// File: tb/card_pwr_seq_tb.sv
module card_pwr_seq_tb;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_pwr = 2'b00;
  logic wr_pol = 1'b0;
  logic card_clk = 1'b0;
  logic tick = 1'b0;
  logic dp_cmd = 1'b0, dp_cmd_oe = 1'b0, dp_dat_oe = 1'b0;
  logic [DATA_W-1:0] dp_dat = 8'h5A;
  logic ck, ck_oe, cmd, cmd_oe, dir_cmd, dir_dat, if_en;
  logic [DATA_W-1:0] dat, dat_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_pwr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_pwr_i(wr_pwr), .wr_pol_i(wr_pol),
    .card_clk_i(card_clk), .card_tick_i(tick),
    .dp_cmd_i(dp_cmd), .dp_cmd_oe_i(dp_cmd_oe), .dp_dat_i(dp_dat), .dp_dat_oe_i(dp_dat_oe),
    .pad_ck_o(ck), .pad_ck_oe_o(ck_oe), .pad_cmd_o(cmd), .pad_cmd_oe_o(cmd_oe),
    .pad_dat_o(dat), .pad_dat_oe_o(dat_oe), .dir_cmd_o(dir_cmd), .dir_dat_o(dir_dat),
    .if_en_o(if_en)
  );

  // {ck_oe, ck, cmd_oe, cmd, dat_oe[7:0], dat[7:0], dir_cmd, dir_dat}
  function automatic logic [21:0] sig();
    return {ck_oe, ck, cmd_oe, cmd, dat_oe, dat, dir_cmd, dir_dat};
  endfunction

  localparam logic [21:0] S_HIZ = 22'h000000;
  localparam logic [21:0] S_CYC = 22'h2BFC03;
  localparam logic [21:0] S_OFF = 22'h3FFFFF;
  localparam logic [21:0] S_ON0 = 22'h2FFFFF; // on, not ready, card_clk low

  // {pol, code, expected signature}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 2'b00, S_HIZ},                // R3 off code in reset keeps reset
    {1'b0, 2'b01, S_HIZ},                // R2
    {1'b1, 2'b01, S_HIZ | 22'h3},        // R2 pol loads, R9
    {1'b0, 2'b10, S_CYC},                // R4
    {1'b0, 2'b01, S_CYC},                // R2
    {1'b1, 2'b10, S_CYC & ~22'h3},       // R9
    {1'b0, 2'b00, S_OFF},                // R5
    {1'b1, 2'b00, S_OFF & ~22'h3},       // R9
    {1'b1, 2'b11, S_ON0 & ~22'h3},       // R6
    {1'b0, 2'b11, S_ON0},                // R6
    {1'b0, 2'b10, S_CYC},                // R1
    {1'b0, 2'b00, S_OFF},                // R1
    {1'b0, 2'b11, S_ON0},                // R1
    {1'b0, 2'b00, S_OFF}                 // R10
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] code, input logic pol, input logic with_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_pwr = code; wr_pol = pol; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset pads", 32'(sig()), 32'(S_HIZ));
    check("R3 reset if_en", 32'(if_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 after release", 32'(sig()), 32'(S_HIZ));

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][23:22], VEC[v][24], 1'b0);
      check($sformatf("R1 vector %0d", v), 32'(sig()), 32'(VEC[v][21:0]));
      check($sformatf("R7 vector %0d if_en", v), 32'(if_en), 0);
    end

    // R7 ticks outside on are ignored, and a tick during the entry write is not counted
    ticks(10);
    wr(2'b11, 1'b0, 1'b1);
    ticks(74);
    check("R7 74 ticks not ready", 32'(if_en), 0);
    check("R6 parked during warm-up", 32'(sig()), 32'(S_ON0));
    card_clk = 1'b1; #1;
    check("R6 clock follows", 32'(ck), 1);
    card_clk = 1'b0;
    ticks(1);
    check("R7 75th tick ready", 32'(if_en), 1);

    // R8 datapath passthrough
    @(negedge clk);
    card_clk = 1'b1; dp_cmd_oe = 1'b1; dp_cmd = 1'b0; dp_dat_oe = 1'b1; dp_dat = 8'h3C;
    #1;
    check("R8 pass drive", 32'(sig()), 32'({1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h3C, 1'b1, 1'b1}));
    dp_cmd_oe = 1'b0; dp_dat_oe = 1'b0; dp_cmd = 1'b1;
    // R11 rewrite on with pol keeps ready
    wr(2'b11, 1'b1, 1'b0);
    check("R11 ready kept", 32'(if_en), 1);
    check("R8 R9 pass release", 32'(sig()), 32'({1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b1, 1'b1}));
    card_clk = 1'b0; dp_dat = 8'h5A; dp_cmd = 1'b0;

    // R10 leave on in the cycle of the completing tick
    wr(2'b00, 1'b0, 1'b0);
    check("R10 off clears", 32'(if_en), 0);
    wr(2'b11, 1'b0, 1'b0);
    ticks(74);
    @(negedge clk);
    wr_en = 1'b1; wr_pwr = 2'b00; wr_pol = 1'b0; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check("R10 collide if_en", 32'(if_en), 0);
    check("R10 collide pads", 32'(sig()), 32'(S_OFF));
    wr(2'b11, 1'b0, 1'b0);
    ticks(74);
    check("R10 count restarted", 32'(if_en), 0);
    ticks(1);
    check("R10 fresh count done", 32'(if_en), 1);

    // R11 rewrite mid-count does not restart
    wr(2'b10, 1'b0, 1'b0);
    wr(2'b11, 1'b0, 1'b0);
    ticks(40);
    wr(2'b11, 1'b0, 1'b0);
    ticks(34);
    check("R11 mid-count 74", 32'(if_en), 0);
    ticks(1);
    check("R11 mid-count 75", 32'(if_en), 1);

    // R3 asynchronous reset from on
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R3 async pads", 32'(sig()), 32'(S_HIZ));
    check("R3 async if_en", 32'(if_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr(2'b01, 1'b0, 1'b0);
    check("R2 reserved after reset", 32'(sig()), 32'(S_HIZ));

    done = 1;
    finish_run();
  end
endmodule